// File: doc/BRIEF.md
# Banked ROM Address Translator

This block sits between a CPU bus, a picture-processor pattern bus and two banked ROMs. The CPU writes three control registers in the $8000-$FFFF range. From them the block turns each CPU address in that range into a wide program-ROM address, and each 13-bit pattern address into a wide character-ROM address. It also drives a nametable mirroring select. RAM and interrupt logic belong to other blocks.

Program space is split into four 8 KB windows. Two of them can be switched, one is fixed to the second-to-last bank, and the top window is fixed to the last bank. A mode bit swaps the first and third windows. Pattern space is split into two 2 KB pages and four 1 KB pages. A second mode bit swaps which half of pattern space holds each kind. Register writes are captured on the clock edge. The translation is combinational from the current addresses and the stored state.

Top module: `bxl_top`

## Requirements
- R1: After synchronous reset all eight bank registers, both mode bits and the index are 0 and mirroring is vertical (`mirror_horiz`=0). So $8000 maps to bank 0, $C000 maps to bank PRG_BANKS-2 and pattern address 0 maps to CHR address 0.
- R2: A write (`cpu_wr`=1) affects state only when `cpu_addr[15]`=1. `cpu_addr[14:13]`=0 with A0=0 is bank-select, `cpu_addr[14:13]`=0 with A0=1 is bank-data, and `cpu_addr[14:13]`=1 with A0=0 is mirroring. All other writes leave every output unchanged.
- R3: Bank-select stores bit 7 as CHR mode, bit 6 as PRG mode and bits 2..0 as the index of the bank register that the next bank-data write loads.
- R4: With PRG mode 0, window $8000-$9FFF uses bank register 6, $A000-$BFFF uses register 7 and $C000-$DFFF uses bank all-ones-minus-one. `prg_addr` is {bank, cpu_addr[12:0]}.
- R5: With PRG mode 1, $8000-$9FFF uses bank all-ones-minus-one and $C000-$DFFF uses register 6. $A000-$BFFF still uses register 7.
- R6: $E000-$FFFF always maps to the all-ones bank, whatever the mode bits hold.
- R7: With CHR mode 0, pattern addresses $0000-$0FFF use 2 KB pages from registers 0 ($0000) and 1 ($0800). The low bit of the stored bank is replaced by pattern A10.
- R8: With CHR mode 0, pattern addresses $1000-$1FFF use 1 KB pages from registers 2 to 5 in ascending order. `chr_addr` is {bank, ppu_addr[9:0]}.
- R9: With CHR mode 1 the lookup uses pattern A12 inverted. The 1 KB pages then cover $0000-$0FFF and the 2 KB pages cover $1000-$1FFF.
- R10: A mirroring write sets `mirror_horiz` to data bit 0 (0 vertical, 1 horizontal).
- R11: A stored bank value wider than the bank field is cut to its low PRG_BANK_W or CHR_BANK_W bits.
- R12: A register write shows up on the outputs in the cycle right after the capturing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address, used for register decode and program translation |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern-space address |
| prg_addr | output | PRG_BANK_W+13 | Translated program-ROM address |
| chr_addr | output | CHR_BANK_W+10 | Translated character-ROM address |
| mirror_horiz | output | 1 | Mirroring select, 1 = horizontal |

## Verification
The assertions check the parts that need no register state, on every cycle:
- the top window always reads the last bank;
- the page offsets pass straight through;
- mirroring loads only on a decoded write and holds otherwise;
- reset clears mirroring.

The mode-dependent window swaps, the 2 KB low-bit substitution, the index-driven loading of bank registers and the truncation of wide values depend on the history of writes. Only the bench's scenarios show these. The bench runs a reference model against random writes and random addresses, plus directed cases.

// File: rtl/bxl_pkg.sv
package bxl_pkg;

    localparam int NUM_BANK_REGS = 8;
    localparam int IDX_W = $clog2(NUM_BANK_REGS);

    typedef logic [NUM_BANK_REGS-1:0][7:0] bank_file_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_SELECT = 2'd1,
        OP_DATA   = 2'd2,
        OP_MIRROR = 2'd3
    } reg_op_e;

    typedef struct packed {
        logic             chr_swap;
        logic             prg_swap;
        logic [IDX_W-1:0] target;
        logic             mirror_h;
    } ctl_t;

    typedef enum logic [1:0] {
        WIN_LOW  = 2'd0,
        WIN_MID  = 2'd1,
        WIN_HIGH = 2'd2,
        WIN_TOP  = 2'd3
    } prg_win_e;

    function automatic reg_op_e decode_op(input logic wr, input logic [15:0] a);
        reg_op_e op;
        op = OP_NONE;
        if (wr && a[15]) begin
            unique case ({a[14:13], a[0]})
                3'b000:  op = OP_SELECT;
                3'b001:  op = OP_DATA;
                3'b010:  op = OP_MIRROR;
                default: op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/bxl_regfile.sv
module bxl_regfile
    import bxl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output ctl_t        ctl,
    output bank_file_t  banks
);
    reg_op_e op;
    logic    unused_addr;

    assign op          = decode_op(cpu_wr, cpu_addr);
    assign unused_addr = ^cpu_addr[12:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (op == OP_SELECT) begin
                ctl.chr_swap <= cpu_wdata[7];
                ctl.prg_swap <= cpu_wdata[6];
                ctl.target   <= cpu_wdata[IDX_W-1:0];
            end
            if (op == OP_MIRROR) begin
                ctl.mirror_h <= cpu_wdata[0];
            end
        end
    end

    for (genvar g = 0; g < NUM_BANK_REGS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                banks[g] <= '0;
            end else if (op == OP_DATA && ctl.target == IDX_W'(g)) begin
                banks[g] <= cpu_wdata;
            end
        end
    end

endmodule

// File: rtl/bxl_prg_map.sv
module bxl_prg_map
    import bxl_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    localparam int OUT_W = PRG_BANK_W + 13
) (
    input  logic [14:0]      cpu_addr,
    input  logic             prg_swap,
    input  logic [7:0]       sw_a,
    input  logic [7:0]       sw_b,
    output logic [OUT_W-1:0] prg_addr
);
    localparam logic [PRG_BANK_W-1:0] LAST_BANK   = '1;
    localparam logic [PRG_BANK_W-1:0] SECOND_LAST = LAST_BANK - 1'b1;

    prg_win_e              win;
    logic [PRG_BANK_W-1:0] bank;
    logic                  unused_hi;

    assign win       = prg_win_e'(cpu_addr[14:13]);
    assign unused_hi = ^{sw_a, sw_b};

    always_comb begin
        unique case (win)
            WIN_LOW:  bank = prg_swap ? SECOND_LAST : sw_a[PRG_BANK_W-1:0];
            WIN_MID:  bank = sw_b[PRG_BANK_W-1:0];
            WIN_HIGH: bank = prg_swap ? sw_a[PRG_BANK_W-1:0] : SECOND_LAST;
            default:  bank = LAST_BANK;
        endcase
    end

    assign prg_addr = {bank, cpu_addr[12:0]};

endmodule

// File: rtl/bxl_chr_map.sv
module bxl_chr_map
    import bxl_pkg::*;
#(
    parameter int CHR_BANK_W = 8,
    localparam int OUT_W = CHR_BANK_W + 10
) (
    input  logic [12:0]      ppu_addr,
    input  logic             chr_swap,
    input  bank_file_t       banks,
    output logic [OUT_W-1:0] chr_addr
);
    logic [1:0][CHR_BANK_W-1:0] big_pg;
    logic [3:0][CHR_BANK_W-1:0] small_pg;
    logic                       half;
    logic [CHR_BANK_W-1:0]      bank;
    logic                       unused_bits;

    for (genvar i = 0; i < 2; i++) begin : g_big
        assign big_pg[i] = {banks[i][CHR_BANK_W-1:1], ppu_addr[10]};
    end
    for (genvar j = 0; j < 4; j++) begin : g_small
        assign small_pg[j] = banks[j+2][CHR_BANK_W-1:0];
    end

    assign half        = ppu_addr[12] ^ chr_swap;
    assign unused_bits = ^{banks[7], banks[6], banks[1][0], banks[0][0], banks};

    always_comb begin
        if (!half) bank = big_pg[ppu_addr[11]];
        else       bank = small_pg[ppu_addr[11:10]];
    end

    assign chr_addr = {bank, ppu_addr[9:0]};

endmodule

// File: rtl/bxl_top.sv
module bxl_top
    import bxl_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8,
    localparam int PRG_OUT_W = PRG_BANK_W + 13,
    localparam int CHR_OUT_W = CHR_BANK_W + 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_wr,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_wdata,
    input  logic [12:0]          ppu_addr,
    output logic [PRG_OUT_W-1:0] prg_addr,
    output logic [CHR_OUT_W-1:0] chr_addr,
    output logic                 mirror_horiz
);
    ctl_t       ctl;
    bank_file_t banks;
    logic       unused_ctl;

    assign unused_ctl = ^{ctl.target, cpu_addr[15]};

    bxl_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .ctl       (ctl),
        .banks     (banks)
    );

    bxl_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .cpu_addr (cpu_addr[14:0]),
        .prg_swap (ctl.prg_swap),
        .sw_a     (banks[6]),
        .sw_b     (banks[7]),
        .prg_addr (prg_addr)
    );

    bxl_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
        .ppu_addr (ppu_addr),
        .chr_swap (ctl.chr_swap),
        .banks    (banks),
        .chr_addr (chr_addr)
    );

    assign mirror_horiz = ctl.mirror_h;

endmodule

// File: rtl/bxl_chk.sv
module bxl_chk #(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cpu_wr,
    input logic [15:0]              cpu_addr,
    input logic [7:0]               cpu_wdata,
    input logic [12:0]              ppu_addr,
    input logic [PRG_BANK_W+12:0]   prg_addr,
    input logic [CHR_BANK_W+9:0]    chr_addr,
    input logic                     mirror_horiz
);
    logic mir_wr;
    assign mir_wr = cpu_wr && cpu_addr[15] && cpu_addr[14:13] == 2'b01 && !cpu_addr[0];

    p_top_last_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[14:13] == 2'b11 |-> &prg_addr[PRG_BANK_W+12:13]);

    p_prg_offset_r4: assert property (@(posedge clk) disable iff (rst)
        prg_addr[12:0] == cpu_addr[12:0]);

    p_chr_offset_r8: assert property (@(posedge clk) disable iff (rst)
        chr_addr[9:0] == ppu_addr[9:0]);

    p_mirror_load_r10: assert property (@(posedge clk) disable iff (rst)
        mir_wr |=> mirror_horiz == $past(cpu_wdata[0]));

    p_mirror_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !mir_wr |=> $stable(mirror_horiz));

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !mirror_horiz);

endmodule

bind bxl_top bxl_chk #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .ppu_addr     (ppu_addr),
    .prg_addr     (prg_addr),
    .chr_addr     (chr_addr),
    .mirror_horiz (mirror_horiz)
);

// File: tb/tb_bxl_top.sv
module tb_bxl_top;
    localparam int PW = 6;
    localparam int CW = 8;

    logic              clk = 0;
    logic              rst = 1;
    logic              cpu_wr = 0;
    logic [15:0]       cpu_addr = 16'h8000;
    logic [7:0]        cpu_wdata = 0;
    logic [12:0]       ppu_addr = 0;
    logic [PW+12:0]    prg_addr;
    logic [CW+9:0]     chr_addr;
    logic              mirror_horiz;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_bank [8];
    logic       m_cm, m_pm, m_mir;
    logic [2:0] m_sel;

    always #5 clk = ~clk;

    bxl_top #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .mirror_horiz(mirror_horiz)
    );

    function automatic logic [PW+12:0] exp_prg(input logic [15:0] a);
        logic [PW-1:0] last, b;
        last = '1;
        case (a[14:13])
            2'd0: b = m_pm ? last - 1'b1 : m_bank[6][PW-1:0];
            2'd1: b = m_bank[7][PW-1:0];
            2'd2: b = m_pm ? m_bank[6][PW-1:0] : last - 1'b1;
            default: b = last;
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [CW+9:0] exp_chr(input logic [12:0] p);
        logic [7:0] b;
        if ((p[12] ^ m_cm) == 1'b0) b = (m_bank[p[11]] & 8'hFE) | {7'd0, p[10]};
        else                        b = m_bank[2 + p[11:10]];
        return {b[CW-1:0], p[9:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_bank[i] = 0;
        m_cm = 0; m_pm = 0; m_mir = 0; m_sel = 0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 0;
        if (a[15] && a[14:13] == 2'd0 && !a[0]) begin
            m_cm = d[7]; m_pm = d[6]; m_sel = d[2:0];
        end else if (a[15] && a[14:13] == 2'd0 && a[0]) begin
            m_bank[m_sel] = d;
        end else if (a[15] && a[14:13] == 2'd1 && !a[0]) begin
            m_mir = d[0];
        end
    endtask

    task automatic probe_prg(input logic [15:0] a);
        string r;
        cpu_addr = a; #1;
        case (a[14:13])
            2'd3: r = "R6";
            2'd1: r = "R4";
            default: r = m_pm ? "R5" : "R4";
        endcase
        check(r, 32'(prg_addr), 32'(exp_prg(a)));
    endtask

    task automatic probe_chr(input logic [12:0] p);
        string r;
        ppu_addr = p; #1;
        if (m_cm) r = "R9";
        else if (p[12]) r = "R8";
        else r = "R7";
        check(r, 32'(chr_addr), 32'(exp_chr(p)));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        cpu_addr = 16'h8123; #1; check("R1", 32'(prg_addr), 32'(19'h00123));
        cpu_addr = 16'hC456; #1; check("R1", 32'(prg_addr), 32'({6'd62, 13'h0456}));
        ppu_addr = 13'h0;    #1; check("R1", 32'(chr_addr), 32'd0);
        check("R1", 32'(mirror_horiz), 32'd0);

        // R3, R12: select then data, visible next cycle
        do_write(16'h8000, 8'h06); do_write(16'h8001, 8'h15);
        probe_prg(16'h8010); check("R12", 32'(prg_addr[18:13]), 32'd21);
        do_write(16'h8000, 8'h46);
        check("R3", 32'(prg_addr[18:13]), 32'd62);
        probe_prg(16'hC000);
        // R11: wide value truncated
        do_write(16'h8001, 8'hFF);
        cpu_addr = 16'hC000; #1; check("R11", 32'(prg_addr[18:13]), 32'd63);
        // R10 and R12
        do_write(16'hA000, 8'h01); check("R10", 32'(mirror_horiz), 32'd1);
        do_write(16'hA000, 8'hFE); check("R10", 32'(mirror_horiz), 32'd0);
        // R2: ignored writes
        do_write(16'hA001, 8'h01); check("R2", 32'(mirror_horiz), 32'd0);
        do_write(16'h2000, 8'hC7); probe_prg(16'h8000);
        check("R2", 32'(prg_addr), 32'(exp_prg(16'h8000)));
        do_write(16'hC000, 8'h80); probe_chr(13'h0000);
        do_write(16'hE001, 8'h55); probe_prg(16'hA000);
        // R7: 2 KB page low bit replaced by A10
        do_write(16'h8000, 8'h00); do_write(16'h8001, 8'h0B);
        ppu_addr = 13'h0000; #1; check("R7", 32'(chr_addr[17:10]), 32'h0A);
        ppu_addr = 13'h0400; #1; check("R7", 32'(chr_addr[17:10]), 32'h0B);
        // R8 and R9
        do_write(16'h8000, 8'h05); do_write(16'h8001, 8'h77);
        ppu_addr = 13'h1C05; #1; check("R8", 32'(chr_addr), 32'({8'h77, 10'h005}));
        do_write(16'h8000, 8'h80);
        ppu_addr = 13'h0C05; #1; check("R9", 32'(chr_addr), 32'({8'h77, 10'h005}));

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            int k;
            k = $urandom_range(0, 9);
            if (k < 3)      a = 16'h8000 | 16'($urandom_range(0, 16'h1FFF) & 16'hFFFE);
            else if (k < 7) a = 16'h8001 | 16'($urandom_range(0, 16'h1FFF));
            else if (k < 8) a = 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
            else            a = 16'($urandom);
            do_write(a, 8'($urandom));
            probe_prg(16'h8000 | 16'($urandom_range(0, 16'h7FFF)));
            probe_chr(13'($urandom));
            check("R10", 32'(mirror_horiz), 32'(m_mir));
        end

        // R1: reset again clears state
        @(negedge clk); rst = 1; @(negedge clk); rst = 0; model_reset();
        probe_prg(16'h8000); probe_chr(13'h1400);
        check("R1", 32'(mirror_horiz), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule